// File: doc/BRIEF.md
# Dual-Direction Byte Queue With Watermarks

This block provides the two holding queues that sit between a host and the bus engine of a serial controller. The transmit queue takes command words from the host, each a data byte plus control bits, and hands them to the engine in order. The receive queue takes bytes from the engine and hands them to the host. Each queue holds sixteen entries. It reports its fill level, raises a watermark flag against a programmable threshold, and pulses an event when a request hits a full or an empty queue.

The engine can hold the transmit queue empty with a flush input, for example while an abort condition is pending. A four-flag status word gives a summary of both queues. Read data is show-ahead: the oldest entry is on the output before the read strobe is applied. Interrupt latching and the bus protocol live outside this block.

Top module: `sfq_top`

## Requirements
- R1: Each queue holds 16 entries and delivers them in the order they were written. A write to a full queue is not stored and leaves the queued entries intact.
- R2: `txLevel` and `rxLevel` are 5-bit counts. They change in the cycle after an accepted write or read. An accepted write and an accepted read in the same cycle leave the count unchanged.
- R3: A host write (`hostTxWr`) while the transmit level is 16 and flush is low produces a one-cycle `txOverEvt` pulse in the following cycle.
- R4: An engine write (`engRxWr`) while the receive level is 16 loses the byte and produces a one-cycle `rxOverEvt` pulse in the following cycle.
- R5: A host read (`hostRxRd`) of an empty receive queue returns 0 on `hostRxByte` and leaves the level at 0. It produces a one-cycle `rxUnderEvt` pulse in the following cycle.
- R6: `txLowMark` is high whenever `txLevel` is less than or equal to the effective transmit threshold.
- R7: `rxHighMark` is high whenever `rxLevel` is greater than or equal to the effective receive threshold, and it falls once reads take the level below it.
- R8: A threshold value of 16 or more acts as an effective threshold of 16. Values 0 to 15 are used as written.
- R9: `fifoStatus` bit 4 is receive level = 16, bit 3 is receive level ≠ 0, bit 2 is transmit level = 0, bit 1 is transmit level ≠ 16, and bit 0 reads 0.
- R10: While `txFlush` is high, the transmit level becomes 0 in the following cycle. Host writes and engine pops are discarded and no transmit overflow event is raised.
- R11: `engTxCmd` and `hostRxByte` show the oldest entry of their queue whenever that queue is not empty. A read strobe advances to the next entry. `engTxCmd` shows 0 when the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostTxWr | input | 1 | Host writes a command word |
| hostTxCmd | input | CMD_W (11) | Command word: byte in [7:0], control bits above |
| engTxPop | input | 1 | Engine consumes the head command |
| engTxCmd | output | CMD_W (11) | Head of transmit queue, 0 when empty |
| txFlush | input | 1 | Hold transmit queue empty |
| engRxWr | input | 1 | Engine delivers a received byte |
| engRxByte | input | 8 | Received byte |
| hostRxRd | input | 1 | Host consumes the head byte |
| hostRxByte | output | 8 | Head of receive queue, 0 when empty |
| txMarkCfg | input | THR_W (8) | Transmit threshold |
| rxMarkCfg | input | THR_W (8) | Receive threshold |
| txLevel | output | 5 | Transmit entries held |
| rxLevel | output | 5 | Receive entries held |
| txLowMark | output | 1 | Transmit level at or below threshold |
| rxHighMark | output | 1 | Receive level at or above threshold |
| txOverEvt | output | 1 | Transmit overflow pulse |
| rxOverEvt | output | 1 | Receive overflow pulse |
| rxUnderEvt | output | 1 | Receive underflow pulse |
| fifoStatus | output | 5 | Summary flags, see R9 |

## Verification
The bench drives each queue past sixteen entries. A design that let the count wrap to 0 or overwrote the oldest entry would show a wrong level and out-of-order data. It programs thresholds above 15, at 0 and at the current level. An off-by-one compare or a missing clamp then flips a watermark flag at the boundary. It also pops and writes in the same cycle on a full queue, and asserts flush while writes are arriving. A design that accepted the write, counted the flushed writes as overflow, or kept stale entries after the flush would be caught by the level, the event pulses and the scoreboard data.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  // log2 of queue depth; the depth is 1 << PTR_W
  localparam int PTR_W = 4;

  // strobes from a queue controller to its storage
  typedef struct packed {
    logic             push;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
  } qStrobe_t;
endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
  parameter int W = 8
) (
  input  logic              clk,
  input  sfq_pkg::qStrobe_t stb,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      rdData
);
  localparam int DEPTH = 1 << sfq_pkg::PTR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.push) mem[stb.wrPtr] <= wrData;
  end

  assign rdData = mem[stb.rdPtr];
endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl #(
  parameter int THR_W      = 8,
  parameter bit MARK_ABOVE = 1'b0,
  parameter bit HAS_UNDER  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrReq,
  input  logic                       rdReq,
  input  logic                       flush,
  input  logic [THR_W-1:0]           thresh,
  output sfq_pkg::qStrobe_t          stb,
  output logic [sfq_pkg::PTR_W:0]    level,
  output logic                       mark,
  output logic                       full,
  output logic                       empty,
  output logic                       overEvt,
  output logic                       underEvt
);
  localparam int PTR_W = sfq_pkg::PTR_W;
  localparam int LVL_W = PTR_W + 1;
  localparam int DEPTH = 1 << PTR_W;

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             push, pop;
  logic [LVL_W-1:0] effThr;

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign push  = wrReq && !full && !flush;
  assign pop   = rdReq && !empty && !flush;

  assign stb.push  = push;
  assign stb.wrPtr = wrPtr;
  assign stb.rdPtr = rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overEvt <= 1'b0;
    else       overEvt <= wrReq && full && !flush;
  end

  generate
    if (HAS_UNDER) begin : g_under
      always_ff @(posedge clk) begin
        if (!rstN) underEvt <= 1'b0;
        else       underEvt <= rdReq && empty && !flush;
      end
    end else begin : g_no_under
      assign underEvt = 1'b0;
    end
  endgenerate

  // thresholds of DEPTH or more clamp to DEPTH
  assign effThr = (thresh >= THR_W'(DEPTH)) ? LVL_W'(DEPTH) : thresh[LVL_W-1:0];

  generate
    if (MARK_ABOVE) begin : g_above
      assign mark = (level >= effThr);
    end else begin : g_below
      assign mark = (level <= effThr);
    end
  endgenerate

  // R1: count never passes the depth
  p_level_cap_r1: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));
  // R1: a full queue with no read stays full whatever is written
  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (full && !flush && !rdReq) |=> full);
  // R3 / R4: write into a full queue yields an overflow pulse
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && full && !flush) |=> overEvt);
  // R5: read of an empty queue flags underflow and stays empty
  p_under_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_UNDER && rdReq && empty && !flush && !wrReq) |=> (underEvt && empty));
  // R10: flush empties the queue without an overflow pulse
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (empty && !overEvt));
endmodule

// File: rtl/sfq_top.sv
module sfq_top #(
  parameter int CMD_W = 11,
  parameter int THR_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostTxWr,
  input  logic [CMD_W-1:0]        hostTxCmd,
  input  logic                    engTxPop,
  output logic [CMD_W-1:0]        engTxCmd,
  input  logic                    txFlush,
  input  logic                    engRxWr,
  input  logic [7:0]              engRxByte,
  input  logic                    hostRxRd,
  output logic [7:0]              hostRxByte,
  input  logic [THR_W-1:0]        txMarkCfg,
  input  logic [THR_W-1:0]        rxMarkCfg,
  output logic [sfq_pkg::PTR_W:0] txLevel,
  output logic [sfq_pkg::PTR_W:0] rxLevel,
  output logic                    txLowMark,
  output logic                    rxHighMark,
  output logic                    txOverEvt,
  output logic                    rxOverEvt,
  output logic                    rxUnderEvt,
  output logic [4:0]              fifoStatus
);
  sfq_pkg::qStrobe_t txStb, rxStb;
  logic [CMD_W-1:0] txRaw;
  logic [7:0]       rxRaw;
  logic txFull, txEmpty, rxFull, rxEmpty, txUnderNc;

  sfq_ctrl #(.THR_W(THR_W), .MARK_ABOVE(1'b0), .HAS_UNDER(1'b0)) u_txCtrl (
    .clk(clk), .rstN(rstN), .wrReq(hostTxWr), .rdReq(engTxPop), .flush(txFlush),
    .thresh(txMarkCfg), .stb(txStb), .level(txLevel), .mark(txLowMark),
    .full(txFull), .empty(txEmpty), .overEvt(txOverEvt), .underEvt(txUnderNc));

  sfq_store #(.W(CMD_W)) u_txStore (
    .clk(clk), .stb(txStb), .wrData(hostTxCmd), .rdData(txRaw));

  sfq_ctrl #(.THR_W(THR_W), .MARK_ABOVE(1'b1), .HAS_UNDER(1'b1)) u_rxCtrl (
    .clk(clk), .rstN(rstN), .wrReq(engRxWr), .rdReq(hostRxRd), .flush(1'b0),
    .thresh(rxMarkCfg), .stb(rxStb), .level(rxLevel), .mark(rxHighMark),
    .full(rxFull), .empty(rxEmpty), .overEvt(rxOverEvt), .underEvt(rxUnderEvt));

  sfq_store #(.W(8)) u_rxStore (
    .clk(clk), .stb(rxStb), .wrData(engRxByte), .rdData(rxRaw));

  assign engTxCmd   = txEmpty ? '0 : txRaw;
  assign hostRxByte = rxEmpty ? '0 : rxRaw;
  assign fifoStatus = {rxFull, !rxEmpty, txEmpty, !txFull, 1'b0};

  // R8: any transmit threshold at or past the depth keeps the low mark up
  p_tx_clamp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txMarkCfg >= THR_W'(16)) |-> txLowMark);
  // R5: the transmit side never reports underflow
  p_tx_no_under_r5: assert property (@(posedge clk) disable iff (!rstN)
    !txUnderNc);
  // R9: the receive full flag implies not empty
  p_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoStatus[4] |-> fifoStatus[3]);
endmodule

// File: tb/sim_sfq_top.sv
module sim_sfq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostTxWr = 0, engTxPop = 0, txFlush = 0, engRxWr = 0, hostRxRd = 0;
  logic [10:0] hostTxCmd = '0;
  logic [7:0]  engRxByte = '0;
  logic [7:0]  txMarkCfg = 8'd4, rxMarkCfg = 8'd8;
  logic [10:0] engTxCmd;
  logic [7:0]  hostRxByte;
  logic [4:0]  txLevel, rxLevel, fifoStatus;
  logic txLowMark, rxHighMark, txOverEvt, rxOverEvt, rxUnderEvt;

  int total = 0, bad = 0;
  bit armed = 0;
  logic [10:0] txQ[$];
  logic [7:0]  rxQ[$];
  bit expTxOver = 0, expRxOver = 0, expRxUnder = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfq_top u0 (
    .clk(clk), .rstN(rstN), .hostTxWr(hostTxWr), .hostTxCmd(hostTxCmd),
    .engTxPop(engTxPop), .engTxCmd(engTxCmd), .txFlush(txFlush),
    .engRxWr(engRxWr), .engRxByte(engRxByte), .hostRxRd(hostRxRd),
    .hostRxByte(hostRxByte), .txMarkCfg(txMarkCfg), .rxMarkCfg(rxMarkCfg),
    .txLevel(txLevel), .rxLevel(rxLevel), .txLowMark(txLowMark),
    .rxHighMark(rxHighMark), .txOverEvt(txOverEvt), .rxOverEvt(rxOverEvt),
    .rxUnderEvt(rxUnderEvt), .fifoStatus(fifoStatus));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int effThr(input logic [7:0] t);
    return (t >= 16) ? 16 : int'(t);
  endfunction

  // monitor / scoreboard: registered outputs reflect the model before this
  // cycle's requests; comb read data reflects the current head
  always @(negedge clk) begin
    if (armed) begin
      int txSz, rxSz;
      txSz = txQ.size();
      rxSz = rxQ.size();
      chk("R2 R10 tx level", int'(txLevel), txSz);
      chk("R2 R1 rx level", int'(rxLevel), rxSz);
      chk("R6 R8 tx low mark", int'(txLowMark), int'(txSz <= effThr(txMarkCfg)));
      chk("R7 R8 rx high mark", int'(rxHighMark), int'(rxSz >= effThr(rxMarkCfg)));
      chk("R3 tx overflow event", int'(txOverEvt), int'(expTxOver));
      chk("R4 rx overflow event", int'(rxOverEvt), int'(expRxOver));
      chk("R5 rx underflow event", int'(rxUnderEvt), int'(expRxUnder));
      chk("R9 status word", int'(fifoStatus),
          int'({rxSz == 16, rxSz != 0, txSz == 0, txSz != 16, 1'b0}));
      chk("R11 tx head", int'(engTxCmd), (txSz != 0) ? int'(txQ[0]) : 0);
      if (hostRxRd)
        chk("R11 R5 rx read data", int'(hostRxByte), (rxSz != 0) ? int'(rxQ[0]) : 0);
      // apply this cycle's requests to the model
      expTxOver  = hostTxWr && !txFlush && txSz == 16;
      expRxOver  = engRxWr && rxSz == 16;
      expRxUnder = hostRxRd && rxSz == 0;
      if (txFlush) txQ.delete();
      else begin
        if (engTxPop && txSz != 0) void'(txQ.pop_front());
        if (hostTxWr && txSz < 16) txQ.push_back(hostTxCmd);
      end
      if (hostRxRd && rxSz != 0) void'(rxQ.pop_front());
      if (engRxWr && rxSz < 16) rxQ.push_back(engRxByte);
    end
  end

  task automatic step(input bit tw, input bit tp, input bit fl, input bit rw, input bit rr);
    @(posedge clk); #1;
    hostTxWr = tw; engTxPop = tp; txFlush = fl; engRxWr = rw; hostRxRd = rr;
    hostTxCmd = 11'($urandom); engRxByte = 8'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // reset state (R2 R9)
    chk("R2 reset tx level", int'(txLevel), 0);
    chk("R9 reset status", int'(fifoStatus), 5'b00110);
    armed = 1;
    // R1 R3: overfill transmit, then pop while writing on full
    for (int i = 0; i < 18; i++) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    txMarkCfg = 8'd20;
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0);
    txMarkCfg = 8'd0;
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 0);
    // R10: flush with writes arriving
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
    // R4 R7 R8: overfill receive with clamped threshold
    rxMarkCfg = 8'd200;
    for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    rxMarkCfg = 8'd8;
    // R5 R7: drain past empty
    for (int i = 0; i < 18; i++) step(0, 0, 0, 0, 1);
    rxMarkCfg = 8'd0;
    step(0, 0, 0, 0, 0);
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 50 == 0) begin
        txMarkCfg = 8'($urandom_range(0, 20));
        rxMarkCfg = 8'($urandom_range(0, 20));
      end
      step($urandom_range(0, 2) != 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 40) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0);
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule